// File: doc/BRIEF.md
# Boundary Scan Test Access Port

This block is a test access port controller together with the boundary register of a small device. A four-wire serial interface (test clock, mode select, data in, data out) drives the standard sixteen-state controller. The controller selects one of three data registers: a one-bit bypass register, a 32-bit identification register, or a boundary register. The boundary register is a chain of cells placed between the device pins and the core logic.

The boundary register uses two kinds of cell. A dedicated input pin has a one-bit cell that can only capture and shift. A bidirectional pin has a three-stage cell. That cell captures the pin level, the core's output data and the core's output enable, and it holds separate update registers for the output data and the output enable. The instruction register selects the boundary register, the identification register or the bypass register. It also decides whether the pads are driven by the core, by the update registers, or released to high impedance.

There is no test reset pin. An active-low power-on reset places the controller in Test-Logic-Reset, and five test clocks with mode select held high do the same from any state.

Top module: `tap_bscan`

## Requirements
- R1: While `porRst_n` is low and right after it rises, the controller is in Test-Logic-Reset, the identification instruction is active, `tdoOe` is 0, and every pad follows `coreOut`/`coreOe`.
- R2: Five rising test clock edges with `tms` high return the controller to Test-Logic-Reset from any state, which makes the identification instruction active again.
- R3: The instruction register is 4 bits wide and captures 4'b0001. It shifts in least-significant bit first, and a new instruction takes effect only on leaving Update-IR.
- R4: The identification instruction (4'b0011) selects a 32-bit register that captures `ID_CODE`, whose bit 0 is 1, and shifts it out least-significant bit first.
- R5: The code 4'b1111 and every code not listed in R4, R6, R7 or R8 select a one-bit bypass register. That register captures 0 and delays `tdi` by one bit.
- R6: The sample/preload instruction (4'b0101) selects the boundary register. It captures pin and core values while the pads keep following the core, and the values shifted in are loaded into the update registers at Update-DR.
- R7: The external test instruction (4'b0000) selects the boundary register and drives every `padOut` and `padOe` from the output and enable update registers.
- R8: The high-impedance instruction (4'b0111) forces every `padOe` to 0 and selects the bypass register.
- R9: `tdo` changes only on the falling edge of `tck`, and `tdoOe` is 1 only while the controller is in Shift-DR or Shift-IR.
- R10: The boundary register is NUM_IN+3*NUM_IO bits long, and bit 0 sits next to `tdo`. Bit i (i<NUM_IN) is input pin i. For pin j, at base NUM_IN+3*j, bit base+0 is the pin level, bit base+1 is the output data and bit base+2 is the output enable.
- R11: The update registers change only at Update-DR while R6 or R7 is the active instruction. A shift under any other instruction leaves them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| porRst_n | input | 1 | Active-low power-on reset |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdoOe | output | 1 | Drive enable for `tdo`; 0 means high impedance |
| inPin | input | NUM_IN | Levels on the dedicated input pins |
| ioPinIn | input | NUM_IO | Levels read back from the bidirectional pins |
| coreOut | input | NUM_IO | Output data from core logic |
| coreOe | input | NUM_IO | Output enables from core logic |
| padOut | output | NUM_IO | Data to the pad drivers |
| padOe | output | NUM_IO | Enables for the pad drivers |

## Verification
The assertions watch several rules on every clock. A run of five high `tms` values always ends in Test-Logic-Reset. The instruction register holds 0001 on entry to Shift-IR. The active instruction changes only after Update-IR or Test-Logic-Reset. `tdoOe` is never raised outside a shift state. The update registers of each pin cell hold their value unless a boundary update strobe came before. Other properties need the bench's scenarios: the length of the register each instruction code selects, and the bit order of the boundary register against the pin layout. The bench also shows that preloaded values reach the pads only under external test, that they survive a shift under another instruction, and that `tdo` holds steady across the rising edge.

// File: rtl/tap_bscan_pkg.sv
package tap_bscan_pkg;
  localparam int IR_W = 4;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tapState_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 4'b0000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 4'b0011;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 4'b0101;
  localparam logic [IR_W-1:0] OP_HIGHZ   = 4'b0111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  // strobes from the controller to the scan datapath
  typedef struct packed {
    logic captureDr;
    logic shiftDr;
    logic updateDr;
    logic shiftIr;
    logic selBsr;
    logic selId;
    logic extest;
    logic highz;
  } tapStrobe_t;
endpackage

// File: rtl/bsc_in_cell.sv
module bsc_in_cell (
  input  logic tck,
  input  logic porRst_n,
  input  logic capture,
  input  logic shift,
  input  logic pinIn,
  input  logic scanIn,
  output logic scanOut
);
  // single capture/shift stage; mux picks pin level or upstream bit
  always_ff @(posedge tck or negedge porRst_n) begin
    if (!porRst_n)    scanOut <= 1'b0;
    else if (capture) scanOut <= pinIn;
    else if (shift)   scanOut <= scanIn;
  end
endmodule

// File: rtl/bsc_io_cell.sv
module bsc_io_cell (
  input  logic tck,
  input  logic porRst_n,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic extest,
  input  logic highz,
  input  logic coreOut,
  input  logic coreOe,
  input  logic pinIn,
  input  logic scanIn,
  output logic scanOut,
  output logic padOut,
  output logic padOe
);
  logic sOe, sOut, sPin;
  logic outUpd, oeUpd;

  // scanIn -> sOe -> sOut -> sPin -> scanOut
  always_ff @(posedge tck or negedge porRst_n) begin
    if (!porRst_n) begin
      sOe <= 1'b0; sOut <= 1'b0; sPin <= 1'b0;
    end else if (capture) begin
      sOe <= coreOe; sOut <= coreOut; sPin <= pinIn;
    end else if (shift) begin
      sOe <= scanIn; sOut <= sOe; sPin <= sOut;
    end
  end

  always_ff @(posedge tck or negedge porRst_n) begin
    if (!porRst_n) begin
      outUpd <= 1'b0; oeUpd <= 1'b0;
    end else if (update) begin
      outUpd <= sOut; oeUpd <= sOe;
    end
  end

  assign scanOut = sPin;
  assign padOut  = extest ? outUpd : coreOut;
  assign padOe   = highz ? 1'b0 : (extest ? oeUpd : coreOe);

  a_r11_update_hold: assert property (@(posedge tck) disable iff (!porRst_n)
    !$past(update) |-> ($stable(outUpd) && $stable(oeUpd)))
    else $error("update registers moved without an update strobe");
endmodule

// File: rtl/tap_fsm.sv
module tap_fsm
  import tap_bscan_pkg::*;
(
  input  logic       tck,
  input  logic       porRst_n,
  input  logic       tms,
  input  logic       tdi,
  output tapStrobe_t strobe,
  output logic       irBit
);
  tapState_e state, nextState;
  logic [IR_W-1:0] irShift, irActive;

  always_comb begin
    unique case (state)
      TLR:    nextState = tms ? TLR    : RTI;
      RTI:    nextState = tms ? SEL_DR : RTI;
      SEL_DR: nextState = tms ? SEL_IR : CAP_DR;
      CAP_DR: nextState = tms ? EX1_DR : SHF_DR;
      SHF_DR: nextState = tms ? EX1_DR : SHF_DR;
      EX1_DR: nextState = tms ? UPD_DR : PAU_DR;
      PAU_DR: nextState = tms ? EX2_DR : PAU_DR;
      EX2_DR: nextState = tms ? UPD_DR : SHF_DR;
      UPD_DR: nextState = tms ? SEL_DR : RTI;
      SEL_IR: nextState = tms ? TLR    : CAP_IR;
      CAP_IR: nextState = tms ? EX1_IR : SHF_IR;
      SHF_IR: nextState = tms ? EX1_IR : SHF_IR;
      EX1_IR: nextState = tms ? UPD_IR : PAU_IR;
      PAU_IR: nextState = tms ? EX2_IR : PAU_IR;
      EX2_IR: nextState = tms ? UPD_IR : SHF_IR;
      default: nextState = tms ? SEL_DR : RTI;
    endcase
  end

  always_ff @(posedge tck or negedge porRst_n) begin
    if (!porRst_n) state <= TLR;
    else           state <= nextState;
  end

  always_ff @(posedge tck or negedge porRst_n) begin
    if (!porRst_n) begin
      irShift  <= IR_CAPTURE;
      irActive <= OP_IDCODE;
    end else begin
      if (state == CAP_IR)      irShift <= IR_CAPTURE;
      else if (state == SHF_IR) irShift <= {tdi, irShift[IR_W-1:1]};
      if (state == TLR)         irActive <= OP_IDCODE;
      else if (state == UPD_IR) irActive <= irShift;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.captureDr = (state == CAP_DR);
    strobe.shiftDr   = (state == SHF_DR);
    strobe.updateDr  = (state == UPD_DR);
    strobe.shiftIr   = (state == SHF_IR);
    case (irActive)
      OP_EXTEST: begin strobe.selBsr = 1'b1; strobe.extest = 1'b1; end
      OP_SAMPLE: strobe.selBsr = 1'b1;
      OP_IDCODE: strobe.selId  = 1'b1;
      OP_HIGHZ:  strobe.highz  = 1'b1;
      default:   ;
    endcase
  end

  assign irBit = irShift[0];

  a_r2_five_ones_reset: assert property (@(posedge tck) disable iff (!porRst_n)
    ($past(tms,1) && $past(tms,2) && $past(tms,3) && $past(tms,4) && $past(tms,5))
    |-> (state == TLR))
    else $error("five high tms did not reach Test-Logic-Reset");

  a_r3_ir_capture: assert property (@(posedge tck) disable iff (!porRst_n)
    (state == SHF_IR && $past(state) == CAP_IR) |-> (irShift == IR_CAPTURE))
    else $error("instruction capture pattern wrong");

  a_r3_ir_update_only: assert property (@(posedge tck) disable iff (!porRst_n)
    (irActive != $past(irActive)) |-> ($past(state) == UPD_IR || $past(state) == TLR))
    else $error("instruction changed outside Update-IR");
endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import tap_bscan_pkg::*;
#(
  parameter int          NUM_IN  = 4,
  parameter int          NUM_IO  = 8,
  parameter logic [31:0] ID_CODE = 32'h5A3C_96E1
)(
  input  logic              tck,
  input  logic              porRst_n,
  input  tapStrobe_t        strobe,
  input  logic              tdi,
  input  logic              irBit,
  input  logic [NUM_IN-1:0] inPin,
  input  logic [NUM_IO-1:0] ioPinIn,
  input  logic [NUM_IO-1:0] coreOut,
  input  logic [NUM_IO-1:0] coreOe,
  output logic [NUM_IO-1:0] padOut,
  output logic [NUM_IO-1:0] padOe,
  output logic              tdo,
  output logic              tdoOe
);
  localparam int NUM_CELL = NUM_IN + NUM_IO;

  logic [NUM_CELL:0] link;
  logic bsrCap, bsrShift, bsrUpd, selBypass;
  logic [31:0] idReg;
  logic bypassReg, drBit;

  assign link[NUM_CELL] = tdi;
  assign bsrCap    = strobe.captureDr && strobe.selBsr;
  assign bsrShift  = strobe.shiftDr && strobe.selBsr;
  assign bsrUpd    = strobe.updateDr && strobe.selBsr;
  assign selBypass = !strobe.selBsr && !strobe.selId;

  generate
    for (genvar c = 0; c < NUM_IN; c++) begin : g_in
      bsc_in_cell u_cell (
        .tck(tck), .porRst_n(porRst_n), .capture(bsrCap), .shift(bsrShift),
        .pinIn(inPin[c]), .scanIn(link[c+1]), .scanOut(link[c]));
    end
    for (genvar j = 0; j < NUM_IO; j++) begin : g_io
      bsc_io_cell u_cell (
        .tck(tck), .porRst_n(porRst_n), .capture(bsrCap), .shift(bsrShift),
        .update(bsrUpd), .extest(strobe.extest), .highz(strobe.highz),
        .coreOut(coreOut[j]), .coreOe(coreOe[j]), .pinIn(ioPinIn[j]),
        .scanIn(link[NUM_IN+j+1]), .scanOut(link[NUM_IN+j]),
        .padOut(padOut[j]), .padOe(padOe[j]));
    end
  endgenerate

  always_ff @(posedge tck or negedge porRst_n) begin
    if (!porRst_n) begin
      idReg     <= '0;
      bypassReg <= 1'b0;
    end else begin
      if (strobe.captureDr && strobe.selId)    idReg <= ID_CODE;
      else if (strobe.shiftDr && strobe.selId) idReg <= {tdi, idReg[31:1]};
      if (strobe.captureDr && selBypass)       bypassReg <= 1'b0;
      else if (strobe.shiftDr && selBypass)    bypassReg <= tdi;
    end
  end

  always_comb begin
    if (strobe.selBsr)     drBit = link[0];
    else if (strobe.selId) drBit = idReg[0];
    else                   drBit = bypassReg;
  end

  // output stage on the falling edge
  always_ff @(negedge tck or negedge porRst_n) begin
    if (!porRst_n) begin
      tdo   <= 1'b0;
      tdoOe <= 1'b0;
    end else begin
      tdoOe <= strobe.shiftDr || strobe.shiftIr;
      tdo   <= strobe.shiftIr ? irBit : (strobe.shiftDr ? drBit : 1'b0);
    end
  end

  a_r9_tdo_only_in_shift: assert property (@(posedge tck) disable iff (!porRst_n)
    tdoOe |-> (strobe.shiftDr || strobe.shiftIr))
    else $error("tdo driven outside a shift state");
endmodule

// File: rtl/tap_bscan.sv
module tap_bscan
  import tap_bscan_pkg::*;
#(
  parameter int          NUM_IN  = 4,
  parameter int          NUM_IO  = 8,
  parameter logic [31:0] ID_CODE = 32'h5A3C_96E1
)(
  input  logic              tck,
  input  logic              porRst_n,
  input  logic              tms,
  input  logic              tdi,
  output logic              tdo,
  output logic              tdoOe,
  input  logic [NUM_IN-1:0] inPin,
  input  logic [NUM_IO-1:0] ioPinIn,
  input  logic [NUM_IO-1:0] coreOut,
  input  logic [NUM_IO-1:0] coreOe,
  output logic [NUM_IO-1:0] padOut,
  output logic [NUM_IO-1:0] padOe
);
  tapStrobe_t strobe;
  logic irBit;

  tap_fsm u_fsm (
    .tck(tck), .porRst_n(porRst_n), .tms(tms), .tdi(tdi),
    .strobe(strobe), .irBit(irBit));

  scan_datapath #(.NUM_IN(NUM_IN), .NUM_IO(NUM_IO), .ID_CODE(ID_CODE)) u_path (
    .tck(tck), .porRst_n(porRst_n), .strobe(strobe), .tdi(tdi), .irBit(irBit),
    .inPin(inPin), .ioPinIn(ioPinIn), .coreOut(coreOut), .coreOe(coreOe),
    .padOut(padOut), .padOe(padOe), .tdo(tdo), .tdoOe(tdoOe));
endmodule

// File: tb/tap_bscan_bench.sv
module tap_bscan_bench;
  localparam int NI = 4;
  localparam int NIO = 8;
  localparam int CH = NI + 3*NIO;
  localparam logic [31:0] ID = 32'h5A3C_96E1;

  // table: {instruction code, expected selected register length}
  localparam logic [11:0] TBL [8] = '{
    {4'b0000, 8'd28}, {4'b0001, 8'd1}, {4'b0011, 8'd32}, {4'b0101, 8'd28},
    {4'b0111, 8'd1},  {4'b1111, 8'd1}, {4'b1010, 8'd1},  {4'b0110, 8'd1}};

  logic tck = 1'b0, porRst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoOe;
  logic [NI-1:0]  inPin = '0;
  logic [NIO-1:0] ioPinIn = '0, coreOut = '0, coreOe = '0;
  logic [NIO-1:0] padOut, padOe;

  int nRun = 0, nFail = 0, edgeViol = 0, oeBad = 0;
  logic lastOe;
  logic [127:0] d;
  logic b;

  tap_bscan #(.NUM_IN(NI), .NUM_IO(NIO), .ID_CODE(ID)) u_tap_bscan (
    .tck(tck), .porRst_n(porRst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdoOe(tdoOe),
    .inPin(inPin), .ioPinIn(ioPinIn), .coreOut(coreOut), .coreOe(coreOe),
    .padOut(padOut), .padOe(padOe));

  always #10 tck = ~tck;

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
  endtask

  task automatic tick(input logic m, input logic di, output logic o);
    tms = m; tdi = di;
    @(negedge tck); #5;
    o = tdo; lastOe = tdoOe;
    @(posedge tck); #1;
    if (o !== tdo) edgeViol++;
  endtask

  task automatic shiftDr(input int n, input logic [127:0] din, output logic [127:0] dout);
    logic x;
    dout = '0;
    tick(1, 0, x); tick(0, 0, x); tick(0, 0, x);
    for (int i = 0; i < n; i++) begin
      tick(i == n-1, din[i], x);
      dout[i] = x;
      if (!lastOe) oeBad++;
    end
    tick(1, 0, x); tick(0, 0, x);
  endtask

  task automatic shiftIr(input logic [3:0] code, output logic [127:0] dout);
    logic x;
    dout = '0;
    tick(1, 0, x); tick(1, 0, x); tick(0, 0, x); tick(0, 0, x);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i], x);
      dout[i] = x;
      if (!lastOe) oeBad++;
    end
    tick(1, 0, x); tick(0, 0, x);
  endtask

  function automatic logic [127:0] mkVec(logic [NI-1:0] a, logic [NIO-1:0] p,
                                          logic [NIO-1:0] o, logic [NIO-1:0] e);
    logic [127:0] v = '0;
    for (int i = 0; i < NI; i++) v[i] = a[i];
    for (int j = 0; j < NIO; j++) begin
      v[NI+3*j] = p[j]; v[NI+3*j+1] = o[j]; v[NI+3*j+2] = e[j];
    end
    return v;
  endfunction

  initial begin
    repeat (20000) @(posedge tck);
    nRun++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] capExp, pre;
    int k;
    inPin = 4'hA; ioPinIn = 8'h3C; coreOut = 8'h96; coreOe = 8'hF0;
    repeat (3) @(posedge tck);
    #1 porRst_n = 1'b1;
    // R1: reset state
    chk(tdoOe == 1'b0, "R1 tdoOe", tdoOe, 0);
    chk(padOut == coreOut && padOe == coreOe, "R1 pads follow core", {padOut, padOe}, {coreOut, coreOe});
    tick(0, 0, b);
    chk(lastOe == 1'b0, "R9 tdoOe low in idle", lastOe, 0);
    shiftDr(32, '0, d);
    chk(d[31:0] == ID, "R1 R4 id after reset", d[31:0], ID);
    chk(d[0] == 1'b1, "R4 id bit0", d[0], 1);

    // R3: instruction capture pattern
    shiftIr(4'b1111, d);
    chk(d[3:0] == 4'b0001, "R3 ir capture", d[3:0], 4'b0001);
    // R5: bypass captures 0
    shiftDr(1, 128'h1, d);
    chk(d[0] == 1'b0, "R5 bypass capture", d[0], 0);

    // table: register length per code (R4 R5 R8 R10)
    inPin = '0; ioPinIn = '0; coreOut = '0; coreOe = 8'hFF;
    for (int t = 0; t < 8; t++) begin
      shiftIr(TBL[t][11:8], d);
      if (TBL[t][11:8] == 4'b0111)
        chk(padOe == '0, "R8 highz pads", padOe, 0);
      shiftDr(81, 128'h1 << 40, d);
      k = 0;
      for (int i = 80; i >= 40; i--) if (d[i]) k = i - 40;
      chk(k == int'(TBL[t][7:0]), "R10 R5 R4 R8 register length", k, TBL[t][7:0]);
    end

    // R6 sample/preload
    inPin = 4'b1010; ioPinIn = 8'h3C; coreOut = 8'h96; coreOe = 8'hF0;
    capExp = mkVec(4'b1010, 8'h3C, 8'h96, 8'hF0);
    pre = mkVec('0, '0, 8'h5B, 8'hC6);
    shiftIr(4'b0101, d);
    shiftDr(CH, pre, d);
    chk(d[CH-1:0] == capExp[CH-1:0], "R6 R10 captured chain", d[CH-1:0], capExp[CH-1:0]);
    chk(padOut == coreOut && padOe == coreOe, "R6 pads untouched", {padOut, padOe}, {coreOut, coreOe});
    // R7 external test drives preloaded values
    shiftIr(4'b0000, d);
    chk(padOut == 8'h5B && padOe == 8'hC6, "R7 extest pads", {padOut, padOe}, {8'h5B, 8'hC6});
    // R11 shift under identification leaves update registers alone
    shiftIr(4'b0011, d);
    chk(padOut == coreOut && padOe == coreOe, "R11 pads back to core", {padOut, padOe}, {coreOut, coreOe});
    shiftDr(32, 128'hFFFF_0000_FFFF, d);
    shiftIr(4'b0000, d);
    chk(padOut == 8'h5B && padOe == 8'hC6, "R11 update hold", {padOut, padOe}, {8'h5B, 8'hC6});
    // R8 high impedance
    shiftIr(4'b0111, d);
    chk(padOe == '0, "R8 all enables low", padOe, 0);

    // R2: five ones from inside Shift-DR
    shiftIr(4'b0000, d);
    tick(1, 0, b); tick(0, 0, b); tick(0, 0, b);
    for (int i = 0; i < 5; i++) tick(1, 0, b);
    tick(0, 0, b);
    chk(padOut == coreOut && padOe == coreOe, "R2 reset drops extest", {padOut, padOe}, {coreOut, coreOe});
    shiftDr(32, '0, d);
    chk(d[31:0] == ID, "R2 id active after reset", d[31:0], ID);

    // R9 edge and enable rules over the whole run
    chk(edgeViol == 0, "R9 tdo stable over rising edge", edgeViol, 0);
    chk(oeBad == 0, "R9 tdoOe high while shifting", oeBad, 0);

    summary();
    $finish;
  end
endmodule